// File: doc/BRIEF.md
# PWM Compare Register Update Controller

This block stands between a processor's register writes and the core of a PWM timer. It keeps four 12-bit compare values (RA, SA, RB, SB), an output matrix field and an output configuration field. Each value has two copies. The processor writes a buffer copy, and the PWM core reads an active copy. The block decides when buffered values reach the active set. This happens at once, at the end of a PWM cycle once RB was the last compare value written, or when a manual hold is released.

A configuration byte selects the update policy, a fifty-percent mode, the ramp mode, the output polarity and the clock source. In fifty-percent mode only the B compare values matter: every update of RB copies the B pair into the A pair. The configuration byte can be read back, with its lowest bit always zero.

Top module: `pwm_cmp_update_ctrl`

## Requirements
- R1: After reset, every buffer, every active value, the configuration byte and all status outputs are zero.
- R2: The configuration byte has these fields: bit 7 fifty-percent, bit 6 autolock, bit 5 lock, bits 4:3 ramp mode, bit 2 polarity, bit 1 clock select and bit 0 reserved. `cfg_rd` returns the last byte written, with bit 0 forced to zero.
- R3: `pol_high` follows bit 2, where 1 means active-high outputs and 0 means active-low. `clk_fast` follows bit 1, where 1 selects the fast clock and 0 the slow clock. `ramp_mode` follows bits 4:3, where 00 is one ramp, 01 is two ramps, 10 is four ramps and 11 is reserved.
- R4: A stored ramp mode of 11 is kept as written and raises `mode_invalid`. Any other code lowers it.
- R5: The write addresses are 0 = RA, 1 = SA, 2 = RB, 3 = SB, 4 = matrix (low 4 bits kept) and 5 = output configuration (low 8 bits kept). Addresses 6 and 7 change nothing. With lock and autolock both clear, a write changes the addressed active value one clock later.
- R6: With lock set and autolock clear, writes reach only the buffers and no active value changes.
- R7: With autolock clear, a configuration write that clears lock copies all buffers into the active set on the same edge.
- R8: With autolock set, a `cycle_end` pulse copies all buffers into the active set only if RB was the last compare value written. Otherwise nothing changes.
- R9: A write to RB sets the "RB last" flag. A write to RA, SA or SB clears it, and so does each autolock transfer. Matrix and output configuration writes leave it unchanged.
- R10: When autolock and lock are both set, the autolock rule of R8 applies. Clearing lock while autolock stays set copies nothing.
- R11: In fifty-percent mode, every update of active RB loads active RA with the new RB value and active SA with the buffered SB value. Writes to RA or SA never change the active RA or SA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Compare/field write strobe |
| wr_addr | input | 3 | Write address (R5 map) |
| wr_data | input | 12 | Write data |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_data | input | 8 | Configuration byte |
| cycle_end | input | 1 | One-cycle pulse at the end of a PWM cycle |
| act_ra | output | 12 | Active RA |
| act_sa | output | 12 | Active SA |
| act_rb | output | 12 | Active RB |
| act_sb | output | 12 | Active SB |
| act_matrix | output | 4 | Active output matrix |
| act_outcfg | output | 8 | Active output configuration |
| cfg_rd | output | 8 | Configuration read-back |
| pol_high | output | 1 | Outputs active high when 1 |
| clk_fast | output | 1 | Fast clock selected when 1 |
| ramp_mode | output | 2 | Ramp mode code |
| mode_invalid | output | 1 | Reserved ramp mode stored |

## Verification
The hold and transfer assertions assume that configuration writes and compare writes arrive in separate cycles. They also assume that `cycle_end` never coincides with a write to RB, so each transfer sees a settled buffer and flag. The stimulus keeps to this by issuing one operation per clock, separated by an idle edge. The bench sweeps all 256 configuration bytes. It then runs a fixed write sequence under every combination of lock, autolock and fifty-percent mode, compared against an arithmetic model of the rules.

// File: rtl/pwm_cmp_update_ctrl.sv
module pwm_cmp_update_ctrl #(
  parameter int CW = 12,
  parameter int MW = 4,
  parameter int OW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          cfg_wr_en,
  input  logic [7:0]    cfg_wr_data,
  input  logic          cycle_end,
  output logic [CW-1:0] act_ra,
  output logic [CW-1:0] act_sa,
  output logic [CW-1:0] act_rb,
  output logic [CW-1:0] act_sb,
  output logic [MW-1:0] act_matrix,
  output logic [OW-1:0] act_outcfg,
  output logic [7:0]    cfg_rd,
  output logic          pol_high,
  output logic          clk_fast,
  output logic [1:0]    ramp_mode,
  output logic          mode_invalid
);

  localparam logic [AW-1:0] A_RA = AW'(0);
  localparam logic [AW-1:0] A_SA = AW'(1);
  localparam logic [AW-1:0] A_RB = AW'(2);
  localparam logic [AW-1:0] A_SB = AW'(3);
  localparam logic [AW-1:0] A_MX = AW'(4);
  localparam logic [AW-1:0] A_OC = AW'(5);

  logic [7:1]    cfg_q;
  logic [CW-1:0] buf_ra, buf_sa, buf_rb, buf_sb;
  logic [MW-1:0] buf_mx;
  logic [OW-1:0] buf_oc;
  logic          rb_last_q;

  wire fifty = cfg_q[7];
  wire alock = cfg_q[6];
  wire lock  = cfg_q[5];

  assign cfg_rd       = {cfg_q, 1'b0};
  assign ramp_mode    = cfg_q[4:3];
  assign pol_high     = cfg_q[2];
  assign clk_fast     = cfg_q[1];
  assign mode_invalid = (cfg_q[4:3] == 2'b11);

  wire auto_xfer    = alock & cycle_end & rb_last_q;
  wire lock_release = cfg_wr_en & lock & ~alock & ~cfg_wr_data[5] & ~cfg_wr_data[6];
  wire xfer         = auto_xfer | lock_release;
  wire direct       = wr_en & ~lock & ~alock;
  wire cmp_other    = wr_en & (wr_addr == A_RA || wr_addr == A_SA || wr_addr == A_SB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr_en) cfg_q <= cfg_wr_data[7:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_ra <= '0; buf_sa <= '0; buf_rb <= '0; buf_sb <= '0;
      buf_mx <= '0; buf_oc <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_RA:    buf_ra <= wr_data;
        A_SA:    buf_sa <= wr_data;
        A_RB:    buf_rb <= wr_data;
        A_SB:    buf_sb <= wr_data;
        A_MX:    buf_mx <= wr_data[MW-1:0];
        A_OC:    buf_oc <= wr_data[OW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_last_q <= 1'b0;
    else if (wr_en && wr_addr == A_RB) rb_last_q <= 1'b1;
    else if (cmp_other || auto_xfer) rb_last_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ra <= '0; act_sa <= '0; act_rb <= '0; act_sb <= '0;
      act_matrix <= '0; act_outcfg <= '0;
    end else if (xfer) begin
      act_ra     <= fifty ? buf_rb : buf_ra;
      act_sa     <= fifty ? buf_sb : buf_sa;
      act_rb     <= buf_rb;
      act_sb     <= buf_sb;
      act_matrix <= buf_mx;
      act_outcfg <= buf_oc;
    end else if (direct) begin
      case (wr_addr)
        A_RA: if (!fifty) act_ra <= wr_data;
        A_SA: if (!fifty) act_sa <= wr_data;
        A_RB: begin
          act_rb <= wr_data;
          if (fifty) begin
            act_ra <= wr_data;
            act_sa <= buf_sb;
          end
        end
        A_SB:    act_sb <= wr_data;
        A_MX:    act_matrix <= wr_data[MW-1:0];
        A_OC:    act_outcfg <= wr_data[OW-1:0];
        default: ;
      endcase
    end
  end

  a_r5_direct_rb: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && wr_addr == A_RB) |=> act_rb == $past(wr_data));

  a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !alock && !lock_release) |=>
      ($stable(act_ra) && $stable(act_sa) && $stable(act_rb) && $stable(act_sb)
       && $stable(act_matrix) && $stable(act_outcfg)));

  a_r8_auto_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alock && !auto_xfer) |=>
      ($stable(act_rb) && $stable(act_sb) && $stable(act_matrix) && $stable(act_outcfg)));

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_xfer && !(wr_en && wr_addr == A_RB)) |=> !rb_last_q);

  a_r11_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && fifty) |=> (act_ra == act_rb && act_sa == act_sb));

  a_r4_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data[4:3] == 2'b11) |=> mode_invalid);

endmodule

// File: tb/pwm_cmp_update_ctrl_bench.sv
module pwm_cmp_update_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int MW = 4;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic cycle_end = 1'b0;
  logic [CW-1:0] act_ra, act_sa, act_rb, act_sb;
  logic [MW-1:0] act_matrix;
  logic [OW-1:0] act_outcfg;
  logic [7:0] cfg_rd;
  logic pol_high, clk_fast, mode_invalid;
  logic [1:0] ramp_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cmp_update_ctrl u_pwm_cmp_update_ctrl (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cfg_wr_en, .cfg_wr_data,
    .cycle_end, .act_ra, .act_sa, .act_rb, .act_sb, .act_matrix, .act_outcfg,
    .cfg_rd, .pol_high, .clk_fast, .ramp_mode, .mode_invalid);

  int n_cmp = 0;
  int n_bad = 0;
  logic [CW-1:0] m_buf [6];
  logic [CW-1:0] m_act [6];
  logic m_rblast = 1'b0;
  logic [7:0] m_cfg = '0;

  task automatic chk(string tag, string what, logic [CW-1:0] got, logic [CW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "act_ra", act_ra, m_act[0]);
    chk(tag, "act_sa", act_sa, m_act[1]);
    chk(tag, "act_rb", act_rb, m_act[2]);
    chk(tag, "act_sb", act_sb, m_act[3]);
    chk(tag, "act_matrix", CW'(act_matrix), m_act[4]);
    chk(tag, "act_outcfg", CW'(act_outcfg), m_act[5]);
  endtask

  task automatic model_xfer();
    for (int i = 2; i < 6; i++) m_act[i] = m_buf[i];
    m_act[0] = m_cfg[7] ? m_buf[2] : m_buf[0];
    m_act[1] = m_cfg[7] ? m_buf[3] : m_buf[1];
  endtask

  task automatic cpu_wr(int a, logic [CW-1:0] d);
    logic [CW-1:0] md;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 6) begin
      md = (a == 4) ? (d & CW'((1 << MW) - 1)) : (a == 5) ? (d & CW'((1 << OW) - 1)) : d;
      if (!m_cfg[5] && !m_cfg[6]) begin
        if (!(m_cfg[7] && a < 2)) m_act[a] = md;
        if (m_cfg[7] && a == 2) begin m_act[0] = md; m_act[1] = m_buf[3]; end
      end
      m_buf[a] = md;
      if (a == 2) m_rblast = 1'b1;
      else if (a < 4) m_rblast = 1'b0;
    end
  endtask

  task automatic end_pulse();
    @(negedge clk);
    cycle_end = 1'b1;
    @(negedge clk);
    cycle_end = 1'b0;
    if (m_cfg[6] && m_rblast) begin model_xfer(); m_rblast = 1'b0; end
  endtask

  task automatic cfg_wr(logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (m_cfg[5] && !m_cfg[6] && !v[5] && !v[6]) model_xfer();
    m_cfg = v & 8'hFE;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    string t;
    for (int i = 0; i < 6; i++) begin m_buf[i] = '0; m_act[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");
    chk("R1", "cfg_rd", CW'(cfg_rd), '0);
    chk("R1", "mode_invalid", CW'(mode_invalid), '0);

    for (int v = 0; v < 256; v++) begin
      cfg_wr(8'(v));
      chk("R2", "cfg_rd", CW'(cfg_rd), CW'(v & 8'hFE));
      chk("R3", "pol_high", CW'(pol_high), CW'((v >> 2) & 1));
      chk("R3", "clk_fast", CW'(clk_fast), CW'((v >> 1) & 1));
      chk("R3", "ramp_mode", CW'(ramp_mode), CW'((v >> 3) & 3));
      chk("R4", "mode_invalid", CW'(mode_invalid), CW'(((v >> 3) & 3) == 3));
      chk_all("R7");
    end
    cfg_wr(8'h00);

    for (int pm = 0; pm < 4; pm++) begin
      for (int ff = 0; ff < 2; ff++) begin
        logic al, lk;
        al = pm[1]; lk = pm[0];
        t = al ? (lk ? "R10" : "R8") : (lk ? "R6" : "R5");
        cfg_wr({1'(ff), al, lk, 2'b01, 1'b1, 1'b0, 1'b0});
        for (int a = 0; a < 8; a++) begin
          cpu_wr(a, CW'(a * 293 + pm * 71 + ff * 517 + 12'h5A3));
          chk_all(ff != 0 ? "R11" : t);
        end
        end_pulse();
        chk_all("R9");
        cpu_wr(2, CW'(pm * 97 + ff * 13 + 12'h3C1));
        cpu_wr(4, CW'(12'hFF7 - pm));
        end_pulse();
        chk_all(t);
        cpu_wr(0, CW'(12'h0E5 + pm * 3 + ff));
        end_pulse();
        chk_all("R9");
        cfg_wr({1'(ff), al, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0});
        chk_all(al ? "R10" : "R7");
        cfg_wr(8'h00);
        chk_all("R7");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule